// File: doc/BRIEF.md
# Multiplexed LCD Waveform Generator

This block turns a display bitmap and a handful of control inputs into drive codes for a time-multiplexed LCD panel. Every common and segment pin gets a three-bit level code naming one of seven fractions of the supply: 0, 1/4, 1/3, 1/2, 2/3, 3/4 or full scale. An external resistor-ladder selector turns each code into a voltage. The scan runs from a slow oscillator tick enable. Each common owns a slot of a fixed number of ticks, and the drive polarity flips after every full frame so that the glass sees no net DC.

Two panel configurations are supported. In the four-common mode the block uses a 1/3 bias ladder. In the eight-common mode it uses a 1/4 bias ladder, and the four lowest segment pins become the extra common lines. Blank and lamp-test overrides force every segment to its off or on waveform without altering the bitmap. A run control parks the scan and grounds the panel. The four highest segment pins can each be switched to a static logic output. The ladder resistor select bit passes straight through.

Top module: `lcd_wave_gen`

## Requirements
- R1: After reset the scan sits in slot 0 with normal polarity, so with the run input high and four-common mode selected, COM1 reads 6 (full scale) and COM2 to COM4 read 2 (1/3).
- R2: In four-common mode, level codes are 0=GND, 1=1/4, 2=1/3, 3=1/2, 4=2/3, 5=3/4, 6=VDD. With normal polarity, the active common is 6, idle commons are 2, an on segment is 0 and an off segment is 4. With inverted polarity these are 0, 4, 6 and 2.
- R3: In eight-common mode, with normal polarity, the active common is 6, idle commons are 1, an on segment is 0 and an off segment is 3. With inverted polarity these are 0, 5, 6 and 3.
- R4: The scan moves to the next slot after every 8 tick pulses. A frame is 4 slots (32 ticks) in four-common mode and 8 slots (64 ticks) in eight-common mode, and polarity inverts at each frame boundary.
- R5: In eight-common mode, segment pins 0 to 3 drive common levels for COM5 to COM8 (active in slots 4 to 7) and their bitmap bits are ignored. In four-common mode they are ordinary segments.
- R6: Blank forces every segment to its off level. Lamp-test alone forces every segment to its on level. Blank wins when both are set. Clearing both shows the bitmap again unchanged.
- R7: While run is low, every common and every segment not configured as a static output reads 0. When run returns, the scan restarts at slot 0 with normal polarity.
- R8: A top pin (segment NSEG-4+k) whose select bit k is 1 reads 6 or 0 from value bit k, whatever the bitmap, the overrides and run. When the select bit is 0, value bit k has no effect.
- R9: Bitmap bit s*8+c chooses the on waveform for segment s during slot c.
- R10: The ladder resistor select output always equals its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle oscillator tick enable |
| run | input | 1 | Scan enable; low parks and grounds the panel |
| eighth | input | 1 | 1 selects eight-common / 1/4 bias, 0 selects four-common / 1/3 bias |
| blank | input | 1 | Force all segments off |
| lamp | input | 1 | Force all segments on |
| gp_sel | input | 4 | Static-output select for the top four segment pins |
| gp_val | input | 4 | Static-output level for the top four segment pins |
| rsel_in | input | 1 | Ladder resistor select |
| bitmap | input | NSEG*8 | Display bits, segment s slot c at s*8+c |
| com_lvl | output | 12 | COM1..COM4 level codes, 3 bits each |
| seg_lvl | output | NSEG*3 | Segment level codes, 3 bits each |
| rsel_out | output | 1 | Ladder resistor select, passed through |

## Verification
The bench goes after the points where the slot and frame counters wrap. It checks one tick before and after a slot edge, and the 32 versus 64 tick frame. A design with an off-by-one or a fixed frame length would show the wrong active common or flip polarity early. It drives pins 0 to 3 in eight-common mode with bitmap bits set. A design that did not hand those pins to COM5 to COM8 would show segment levels there. It also sets blank and lamp together, and a wrong priority would light the panel. Static outputs are probed under blank and with run low, so a design that let the scan logic leak into them would ground or modulate those pins.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    localparam int LVW    = 3;
    localparam int MAXCOM = 8;
    localparam int SLOTW  = $clog2(MAXCOM);

    typedef enum logic [LVW-1:0] {
        LV_GND  = 3'd0,
        LV_Q1   = 3'd1,
        LV_T1   = 3'd2,
        LV_HALF = 3'd3,
        LV_T2   = 3'd4,
        LV_Q3   = 3'd5,
        LV_VDD  = 3'd6
    } lvl_e;

    typedef struct packed {
        logic [SLOTW-1:0] slot;
        logic             inv;
    } phase_t;

    function automatic lvl_e com_code(logic active, logic inv, logic eighth);
        if (active)      return inv ? LV_GND : LV_VDD;
        else if (eighth) return inv ? LV_Q3  : LV_Q1;
        else             return inv ? LV_T2  : LV_T1;
    endfunction

    function automatic lvl_e seg_code(logic on, logic inv, logic eighth);
        if (on)          return inv ? LV_VDD : LV_GND;
        else if (eighth) return LV_HALF;
        else             return inv ? LV_T1  : LV_T2;
    endfunction

endpackage

// File: rtl/lcdw_timing.sv
module lcdw_timing
    import lcdw_pkg::*;
#(
    parameter int SLOT_TICKS = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   run,
    input  logic   eighth,
    output phase_t ph
);
    localparam int SUBW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
    localparam logic [SUBW-1:0] SUB_LAST = SUBW'(SLOT_TICKS - 1);

    logic [SUBW-1:0]  sub_q;
    logic [SLOTW-1:0] last_slot;

    assign last_slot = eighth ? SLOTW'(MAXCOM - 1) : SLOTW'(MAXCOM / 2 - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sub_q <= '0;
            ph    <= '0;
        end else if (tick) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                if (ph.slot >= last_slot) begin
                    ph.slot <= '0;
                    ph.inv  <= ~ph.inv;
                end else begin
                    ph.slot <= ph.slot + 1'b1;
                end
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcdw_com_drv.sv
module lcdw_com_drv
    import lcdw_pkg::*;
#(
    parameter int NCOM = 4
) (
    input  phase_t                ph,
    input  logic                  run,
    input  logic                  eighth,
    output logic [NCOM*LVW-1:0]   com_o
);
    for (genvar c = 0; c < NCOM; c++) begin : g_com
        assign com_o[c*LVW +: LVW] = run ?
            com_code(ph.slot == SLOTW'(c), ph.inv, eighth) : LV_GND;
    end
endmodule

// File: rtl/lcdw_seg_drv.sv
module lcdw_seg_drv
    import lcdw_pkg::*;
#(
    parameter int NSEG   = 44,
    parameter int NGP    = 4,
    parameter int NSHARE = 4
) (
    input  phase_t                   ph,
    input  logic                     run,
    input  logic                     eighth,
    input  logic                     blank,
    input  logic                     lamp,
    input  logic [NGP-1:0]           gp_sel,
    input  logic [NGP-1:0]           gp_val,
    input  logic [NSEG*MAXCOM-1:0]   bitmap,
    output logic [NSEG*LVW-1:0]      seg_o
);
    localparam int GP_BASE = NSEG - NGP;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [MAXCOM-1:0] row;
        logic              on;
        lvl_e              scan_lvl;

        assign row      = bitmap[s*MAXCOM +: MAXCOM];
        assign on       = blank ? 1'b0 : (lamp ? 1'b1 : row[ph.slot]);
        assign scan_lvl = run ? seg_code(on, ph.inv, eighth) : LV_GND;

        if (s < NSHARE) begin : g_shared
            assign seg_o[s*LVW +: LVW] = (run && eighth) ?
                com_code(ph.slot == SLOTW'(s + MAXCOM / 2), ph.inv, 1'b1) : scan_lvl;
        end else if (s >= GP_BASE) begin : g_gp
            assign seg_o[s*LVW +: LVW] = gp_sel[s-GP_BASE] ?
                (gp_val[s-GP_BASE] ? LV_VDD : LV_GND) : scan_lvl;
        end else begin : g_plain
            assign seg_o[s*LVW +: LVW] = scan_lvl;
        end
    end
endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
    import lcdw_pkg::*;
#(
    parameter int NSEG       = 44,
    parameter int SLOT_TICKS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     run,
    input  logic                     eighth,
    input  logic                     blank,
    input  logic                     lamp,
    input  logic [3:0]               gp_sel,
    input  logic [3:0]               gp_val,
    input  logic                     rsel_in,
    input  logic [NSEG*8-1:0]        bitmap,
    output logic [11:0]              com_lvl,
    output logic [NSEG*3-1:0]        seg_lvl,
    output logic                     rsel_out
);
    localparam int NCOM = MAXCOM / 2;

    phase_t ph;

    lcdw_timing #(.SLOT_TICKS(SLOT_TICKS)) u_timing (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (run),
        .eighth (eighth),
        .ph     (ph)
    );

    lcdw_com_drv #(.NCOM(NCOM)) u_com (
        .ph     (ph),
        .run    (run),
        .eighth (eighth),
        .com_o  (com_lvl)
    );

    lcdw_seg_drv #(.NSEG(NSEG), .NGP(4), .NSHARE(NCOM)) u_seg (
        .ph     (ph),
        .run    (run),
        .eighth (eighth),
        .blank  (blank),
        .lamp   (lamp),
        .gp_sel (gp_sel),
        .gp_val (gp_val),
        .bitmap (bitmap),
        .seg_o  (seg_lvl)
    );

    assign rsel_out = rsel_in;
endmodule

// File: rtl/lcd_wave_gen_chk.sv
module lcd_wave_gen_chk #(
    parameter int NSEG = 44
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              run,
    input logic              eighth,
    input logic              blank,
    input logic [3:0]        gp_sel,
    input logic [3:0]        gp_val,
    input logic [11:0]       com_lvl,
    input logic [NSEG*3-1:0] seg_lvl
);
    logic       com_third_ok;
    logic       com_quarter_ok;
    logic [2:0] probe_seg;
    logic [2:0] gp0_pin;

    always_comb begin
        com_third_ok   = 1'b1;
        com_quarter_ok = 1'b1;
        for (int c = 0; c < 4; c++) begin
            if (!(com_lvl[c*3 +: 3] inside {3'd0, 3'd2, 3'd4, 3'd6})) com_third_ok = 1'b0;
            if (!(com_lvl[c*3 +: 3] inside {3'd0, 3'd1, 3'd5, 3'd6})) com_quarter_ok = 1'b0;
        end
    end

    assign probe_seg = seg_lvl[4*3 +: 3];
    assign gp0_pin   = seg_lvl[(NSEG-4)*3 +: 3];

    // R1 / R2: four-common mode commons use only the 1/3 ladder taps
    a_r2_third_bias_com: assert property (@(posedge clk) disable iff (rst)
        (run && !eighth) |-> com_third_ok);

    // R3: eight-common mode commons use only the 1/4 ladder taps
    a_r3_quarter_bias_com: assert property (@(posedge clk) disable iff (rst)
        (run && eighth) |-> com_quarter_ok);

    a_r7_stop_grounds_com: assert property (@(posedge clk) disable iff (rst)
        !run |-> (com_lvl == 12'd0));

    a_r6_blank_off_level: assert property (@(posedge clk) disable iff (rst)
        (run && blank && !eighth) |-> (probe_seg == 3'd2 || probe_seg == 3'd4));

    a_r8_gp_static: assert property (@(posedge clk) disable iff (rst)
        gp_sel[0] |-> (gp0_pin == (gp_val[0] ? 3'd6 : 3'd0)));

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(rst) && !$past(tick) && $stable(eighth))
        |-> $stable(com_lvl));
endmodule

bind lcd_wave_gen lcd_wave_gen_chk #(.NSEG(NSEG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (run),
    .eighth  (eighth),
    .blank   (blank),
    .gp_sel  (gp_sel),
    .gp_val  (gp_val),
    .com_lvl (com_lvl),
    .seg_lvl (seg_lvl)
);

// File: tb/sim_lcd_wave_gen.sv
`timescale 1ns/1ps
module sim_lcd_wave_gen;
    localparam int NSEG = 44;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              run = 1'b0;
    logic              eighth = 1'b0;
    logic              blank = 1'b0;
    logic              lamp = 1'b0;
    logic [3:0]        gp_sel = 4'd0;
    logic [3:0]        gp_val = 4'd0;
    logic              rsel_in = 1'b0;
    logic [NSEG*8-1:0] bitmap = '0;
    logic [11:0]       com_lvl;
    logic [NSEG*3-1:0] seg_lvl;
    logic              rsel_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lcd_wave_gen #(.NSEG(NSEG), .SLOT_TICKS(8)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .eighth(eighth),
        .blank(blank), .lamp(lamp), .gp_sel(gp_sel), .gp_val(gp_val),
        .rsel_in(rsel_in), .bitmap(bitmap), .com_lvl(com_lvl),
        .seg_lvl(seg_lvl), .rsel_out(rsel_out)
    );

    function automatic int exp_com(bit act, bit inv, bit e8);
        if (act) return inv ? 0 : 6;
        if (e8)  return inv ? 5 : 1;
        return inv ? 4 : 2;
    endfunction

    function automatic int exp_seg(bit on, bit inv, bit e8);
        if (on) return inv ? 6 : 0;
        if (e8) return 3;
        return inv ? 2 : 4;
    endfunction

    function automatic int com_at(int c);
        return int'(com_lvl[c*3 +: 3]);
    endfunction

    function automatic int seg_at(int s);
        return int'(seg_lvl[s*3 +: 3]);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic setbit(int s, int c, bit v);
        bitmap[s*8 + c] = v;
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        run = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R7", "com idle after reset", int'(com_lvl), 0);
        chk("R7", "seg10 idle after reset", seg_at(10), 0);
        rsel_in = 1'b1;
        #1;
        chk("R10", "rsel follows 1", int'(rsel_out), 1);
        rsel_in = 1'b0;
        #1;
        chk("R10", "rsel follows 0", int'(rsel_out), 0);
        run = 1'b1;
        #1;
        chk("R1", "COM1 active", com_at(0), 6);
        chk("R1", "COM2 idle", com_at(1), 2);
        chk("R1", "COM4 idle", com_at(3), 2);
        chk("R2", "seg5 off", seg_at(5), 4);
    endtask

    task automatic t_quarter();
        eighth = 1'b0;
        bitmap = '0;
        setbit(5, 0, 1'b1);
        setbit(7, 1, 1'b1);
        restart();
        chk("R9", "seg5 on in slot0", seg_at(5), 0);
        chk("R9", "seg7 off in slot0", seg_at(7), 4);
        pulse(7);
        chk("R4", "COM1 still active after 7 ticks", com_at(0), 6);
        pulse(1);
        chk("R4", "COM2 active after 8 ticks", com_at(1), 6);
        chk("R2", "COM1 idle in slot1", com_at(0), 2);
        chk("R9", "seg7 on in slot1", seg_at(7), 0);
        chk("R9", "seg5 off in slot1", seg_at(5), 4);
        pulse(16);
        chk("R4", "COM4 active in slot3", com_at(3), 6);
        pulse(8);
        chk("R4", "frame 32 inverts COM1", com_at(0), exp_com(1, 1, 0));
        chk("R2", "COM3 idle inverted", com_at(2), exp_com(0, 1, 0));
        chk("R2", "seg5 on inverted", seg_at(5), exp_seg(1, 1, 0));
        chk("R2", "seg7 off inverted", seg_at(7), exp_seg(0, 1, 0));
    endtask

    task automatic t_eighth();
        eighth = 1'b1;
        bitmap = '0;
        setbit(10, 5, 1'b1);
        setbit(0, 4, 1'b1);
        restart();
        chk("R3", "COM1 active", com_at(0), exp_com(1, 0, 1));
        chk("R3", "COM2 idle", com_at(1), exp_com(0, 0, 1));
        chk("R5", "pin0 as idle COM5", seg_at(0), exp_com(0, 0, 1));
        chk("R3", "seg10 off", seg_at(10), exp_seg(0, 0, 1));
        pulse(32);
        chk("R5", "pin0 active COM5 in slot4", seg_at(0), 6);
        chk("R3", "COM1 idle in slot4", com_at(0), 1);
        pulse(8);
        chk("R5", "pin1 active COM6 in slot5", seg_at(1), 6);
        chk("R5", "pin0 idle in slot5", seg_at(0), 1);
        chk("R3", "seg10 on in slot5", seg_at(10), exp_seg(1, 0, 1));
        pulse(16);
        chk("R4", "pin3 active COM8 in slot7", seg_at(3), 6);
        chk("R4", "no inversion before 64", com_at(0), 1);
        pulse(8);
        chk("R4", "frame 64 inverts COM1", com_at(0), exp_com(1, 1, 1));
        chk("R3", "COM2 idle inverted", com_at(1), exp_com(0, 1, 1));
        chk("R5", "pin0 idle inverted", seg_at(0), exp_com(0, 1, 1));
        chk("R3", "seg10 off inverted", seg_at(10), 3);
        eighth = 1'b0;
        bitmap = '0;
        setbit(0, 0, 1'b1);
        restart();
        chk("R5", "pin0 segment in four-common mode", seg_at(0), 0);
        chk("R5", "pin1 segment off", seg_at(1), 4);
    endtask

    task automatic t_override();
        eighth = 1'b0;
        bitmap = '0;
        setbit(5, 0, 1'b1);
        restart();
        blank = 1'b1;
        #1;
        chk("R6", "blank forces seg5 off", seg_at(5), 4);
        chk("R6", "blank seg6 off", seg_at(6), 4);
        blank = 1'b0;
        lamp = 1'b1;
        #1;
        chk("R6", "lamp forces seg6 on", seg_at(6), 0);
        chk("R6", "lamp seg5 on", seg_at(5), 0);
        blank = 1'b1;
        #1;
        chk("R6", "blank beats lamp", seg_at(6), 4);
        blank = 1'b0;
        lamp = 1'b0;
        #1;
        chk("R6", "bitmap back seg5", seg_at(5), 0);
        chk("R6", "bitmap back seg6", seg_at(6), 4);
    endtask

    task automatic t_gp();
        eighth = 1'b0;
        bitmap = '0;
        setbit(43, 0, 1'b1);
        gp_sel = 4'b0101;
        gp_val = 4'b1011;
        restart();
        chk("R8", "pin40 static high", seg_at(40), 6);
        chk("R8", "pin42 static low", seg_at(42), 0);
        chk("R8", "pin41 value ignored", seg_at(41), 4);
        chk("R8", "pin43 shows bitmap", seg_at(43), 0);
        blank = 1'b1;
        #1;
        chk("R8", "pin40 ignores blank", seg_at(40), 6);
        chk("R6", "pin43 blanked", seg_at(43), 4);
        blank = 1'b0;
        @(negedge clk);
        run = 1'b0;
        #1;
        chk("R8", "pin40 held while stopped", seg_at(40), 6);
        chk("R7", "pin41 grounded while stopped", seg_at(41), 0);
        chk("R7", "com grounded while stopped", int'(com_lvl), 0);
        pulse(20);
        run = 1'b1;
        #1;
        chk("R7", "restart at slot0 COM1", com_at(0), 6);
        chk("R7", "restart polarity normal", com_at(1), 2);
        gp_sel = 4'd0;
        gp_val = 4'd0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_quarter();
        t_eighth();
        t_override();
        t_gp();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule